// File: doc/BRIEF.md
# Dual Encoder Interrupt Controller

This block watches two quadrature shaft encoders whose phase lines share pins with the low four bits of a general-purpose port. Each phase line passes through a two-flop synchronizer. A change on either phase of an encoder that software has enabled sets one shared, sticky pending flag. The block raises a single interrupt from that flag.

The interrupt leaves the block as an output-enable for an open-drain pad. While `irq_oe` is 1 the pad pulls the shared request line low. While it is 0 the pad is left undriven. A master enable in the control word masks the output but keeps the pending flag intact. The host clears the flag by reading a dedicated status register, which is signalled to the block as a one-cycle strobe. Position counting, vectors and daisy-chaining belong elsewhere.

Top module: `enc_irq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `irq_oe` is 0 and no request is pending.
- R2: Encoder 0 uses phase A on `port_pins[0]` and phase B on `port_pins[1]`. Encoder 1 uses A on `port_pins[2]` and B on `port_pins[3]`. A change in either direction on any one of these four bits counts as movement. `port_pins[7:4]` never affect the request.
- R3: A pin change that is set up before rising edge k sets the pending flag at edge k+2, so `irq_oe` (with the master enable on) is 1 after edge k+2 and not before.
- R4: `ctrl_word[1]` enables encoder 0 and `ctrl_word[2]` enables encoder 1. Movement on an encoder whose bit is 0 does not set the pending flag.
- R5: Once set, the pending flag stays set until a rising edge at which `clr_rd` is 1. At that edge it clears, unless R7 applies.
- R6: `irq_oe` equals `ctrl_word[0]` AND the pending flag. Setting `ctrl_word[0]` to 0 masks the output without clearing the flag, and the flag shows again as soon as the bit returns to 1.
- R7: If enabled movement is detected at the same edge that samples `clr_rd` = 1, the flag is set after that edge, so the event is not lost.
- R8: Pin levels present when reset is released are not reported as movement. No pending flag is set during the first three rising edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, released synchronously |
| port_pins | input | 8 | Port pin levels. Bits 3:0 carry the encoder phases |
| ctrl_word | input | 8 | Control register. Bit 0 is the master enable; bits 1 and 2 are the per-encoder enables |
| clr_rd | input | 1 | One-cycle strobe, high when the host reads the clearing status register |
| irq_oe | output | 1 | Pull-down enable for the open-drain request pad |

## Verification
The bound checker checks on every cycle that:
- the output never rises without the master enable;
- the flag never rises without a detected movement and an enabled encoder in the cycle before;
- a clearing read with no coincident event drops the flag, while the flag otherwise holds;
- a coincident event survives the read;
- the flag stays clear during the start-up window.

Only the bench scenarios can show:
- the exact three-edge latency from a pin change;
- which pin bits belong to which encoder;
- that the upper port bits are ignored;
- that a masked flag reappears when the master enable returns.

The bench covers these with directed steps and then with a random phase, compared against a behavioural reference model on every cycle.

// File: rtl/enc_irq_pkg.sv
package enc_irq_pkg;

  // control word bit positions
  localparam int CTL_MASTER   = 0;
  localparam int CTL_ENC_BASE = 1;

  // synchronizer depth ahead of edge detection
  localparam int SYNC_DEPTH = 2;

  // a phase pair moved if either line differs from its previous sample
  function automatic logic pair_moved(input logic [1:0] now_ph,
                                      input logic [1:0] old_ph);
    return (now_ph[0] ^ old_ph[0]) | (now_ph[1] ^ old_ph[1]);
  endfunction

  // sticky flag: a new event wins over a clearing read
  function automatic logic flag_next(input logic pend,
                                     input logic set_ev,
                                     input logic clr);
    return set_ev | (pend & ~clr);
  endfunction

  // pad pull-down only when unmasked and pending
  function automatic logic drive_low(input logic master,
                                     input logic pend);
    return master & pend;
  endfunction

endpackage

// File: rtl/enc_sync.sv
module enc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= din;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/enc_motion.sv
module enc_motion
  import enc_irq_pkg::*;
#(
  parameter int NUM_ENC   = 2,
  parameter int PRIME_CYC = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*NUM_ENC-1:0] sync_pins,
  output logic [NUM_ENC-1:0]   moved,
  output logic                 primed
);

  localparam int PINS  = 2 * NUM_ENC;
  localparam int CNT_W = $clog2(PRIME_CYC + 1);
  localparam logic [CNT_W-1:0] PRIME_LIM = CNT_W'(PRIME_CYC);

  logic [PINS-1:0]  prev_q;
  logic [CNT_W-1:0] warm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      warm_q <= '0;
    end else begin
      prev_q <= sync_pins;
      if (warm_q != PRIME_LIM) warm_q <= warm_q + 1'b1;
    end
  end

  assign primed = (warm_q == PRIME_LIM);

  for (genvar e = 0; e < NUM_ENC; e++) begin : g_enc
    assign moved[e] = primed & pair_moved(sync_pins[2*e +: 2], prev_q[2*e +: 2]);
  end

endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import enc_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_rd,
  output logic pend_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= flag_next(pend_q, set_evt, clr_rd);
  end

endmodule

// File: rtl/enc_irq_ctrl.sv
module enc_irq_ctrl
  import enc_irq_pkg::*;
#(
  parameter int PORT_W  = 8,
  parameter int CTL_W   = 8,
  parameter int NUM_ENC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] port_pins,
  input  logic [CTL_W-1:0]  ctrl_word,
  input  logic              clr_rd,
  output logic              irq_oe
);

  localparam int ENC_PINS  = 2 * NUM_ENC;
  localparam int CTL_USED  = CTL_ENC_BASE + NUM_ENC;
  localparam int PRIME_CYC = SYNC_DEPTH + 1;

  logic [ENC_PINS-1:0] sync_pins;
  logic [NUM_ENC-1:0]  moved;
  logic [NUM_ENC-1:0]  enc_en;
  logic                primed;
  logic                set_evt;
  logic                pend_q;

  enc_sync #(.W(ENC_PINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (port_pins[ENC_PINS-1:0]),
    .dout  (sync_pins)
  );

  enc_motion #(.NUM_ENC(NUM_ENC), .PRIME_CYC(PRIME_CYC)) u_motion (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_pins (sync_pins),
    .moved     (moved),
    .primed    (primed)
  );

  assign enc_en  = ctrl_word[CTL_ENC_BASE +: NUM_ENC];
  assign set_evt = |(moved & enc_en);

  irq_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .clr_rd  (clr_rd),
    .pend_q  (pend_q)
  );

  assign irq_oe = drive_low(ctrl_word[CTL_MASTER], pend_q);

  if (PORT_W > ENC_PINS) begin : g_port_spare
    logic unused_port;
    assign unused_port = ^port_pins[PORT_W-1:ENC_PINS];
  end
  if (CTL_W > CTL_USED) begin : g_ctl_spare
    logic unused_ctl;
    assign unused_ctl = ^ctrl_word[CTL_W-1:CTL_USED];
  end
  logic unused_primed;
  assign unused_primed = primed;

endmodule

// File: rtl/enc_irq_chk.sv
module enc_irq_chk #(
  parameter int CTL_W   = 8,
  parameter int NUM_ENC = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CTL_W-1:0] ctrl_word,
  input logic             clr_rd,
  input logic             irq_oe,
  input logic             pend_q,
  input logic             set_evt
);

  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R6
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_oe |-> ctrl_word[0]);

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(set_evt));

  // R4
  rise_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(|ctrl_word[1 +: NUM_ENC]));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_rd) |=> pend_q);

  // R5
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !set_evt) |=> !pend_q);

  // R7
  keep_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && set_evt) |=> pend_q);

  // R8
  warmup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> !pend_q);

endmodule

bind enc_irq_ctrl enc_irq_chk #(.CTL_W(CTL_W), .NUM_ENC(NUM_ENC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ctrl_word (ctrl_word),
  .clr_rd    (clr_rd),
  .irq_oe    (irq_oe),
  .pend_q    (pend_q),
  .set_evt   (set_evt)
);

// File: tb/enc_irq_ctrl_tb.sv
`timescale 1ns/1ps
module enc_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pins = 8'h0F;
  logic [7:0] ctrl = 8'h07;
  logic       clr_rd = 1'b0;
  logic       irq_oe;

  int    vectors = 0;
  int    miscompares = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  enc_irq_ctrl u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_pins (pins),
    .ctrl_word (ctrl),
    .clr_rd    (clr_rd),
    .irq_oe    (irq_oe)
  );

  // behavioural reference: history of pin samples, one per edge since reset
  logic [7:0] hist[$];
  int         edges;
  bit         m_pend;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      edges  = 0;
      m_pend = 1'b0;
    end else begin
      bit ev;
      ev = 1'b0;
      edges++;
      // detection at edge m compares samples from edges m-2 and m-3
      if (edges >= 4) begin
        for (int e = 0; e < 2; e++) begin
          if (hist[edges-3][2*e +: 2] != hist[edges-4][2*e +: 2] && ctrl[1+e])
            ev = 1'b1;
        end
      end
      m_pend = ev || (m_pend && !clr_rd);
      hist.push_back(pins);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      logic exp_oe;
      exp_oe = m_pend && ctrl[0];
      vectors++;
      if (irq_oe !== exp_oe) begin
        miscompares++;
        $display("FAIL %s model compare at %0t: irq_oe=%b expected=%b",
                 cur_req, $time, irq_oe, exp_oe);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s directed at %0t: irq_oe=%b expected=%b", req, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic probe(input string req, input logic exp);
    @(negedge clk);
    #1;
    chk(req, irq_oe, exp);
  endtask

  task automatic host_read();
    step();
    clr_rd = 1'b1;
    step();
    clr_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    // R1: reset with nonzero pin levels
    cur_req = "R1";
    steps(3);
    probe("R1", 1'b0);
    step();
    rst_n = 1'b1;
    probe("R1", 1'b0);

    // R8: levels held at release are not movement
    cur_req = "R8";
    steps(6);
    probe("R8", 1'b0);

    // R3: latency of exactly three edges
    cur_req = "R3";
    step();
    pins[0] = ~pins[0];
    @(posedge clk); probe("R3", 1'b0);
    @(posedge clk); probe("R3", 1'b0);
    @(posedge clk); probe("R3", 1'b1);

    // R5: sticky until read, then cleared
    cur_req = "R5";
    steps(5);
    probe("R5", 1'b1);
    host_read();
    probe("R5", 1'b0);

    // R2: upper port bits ignored, encoder 1 phase B counts
    cur_req = "R2";
    step();
    pins[7:4] = ~pins[7:4];
    steps(6);
    probe("R2", 1'b0);
    pins[3] = ~pins[3];
    steps(4);
    probe("R2", 1'b1);
    host_read();
    probe("R2", 1'b0);

    // R4: per-encoder enables
    cur_req = "R4";
    step();
    ctrl = 8'h03;
    pins[2] = ~pins[2];
    steps(6);
    probe("R4", 1'b0);
    pins[1] = ~pins[1];
    steps(4);
    probe("R4", 1'b1);
    host_read();
    ctrl = 8'h05;
    pins[1] = ~pins[1];
    steps(6);
    probe("R4", 1'b0);

    // R6: master masks but keeps the flag
    cur_req = "R6";
    ctrl = 8'h06;
    pins[0] = ~pins[0];
    steps(6);
    probe("R6", 1'b0);
    ctrl = 8'h07;
    probe("R6", 1'b1);

    // R7: event coincides with the clearing read
    cur_req = "R7";
    step();
    pins[3] = ~pins[3];
    step();
    step();
    clr_rd = 1'b1;
    step();
    clr_rd = 1'b0;
    probe("R7", 1'b1);
    host_read();
    probe("R5", 1'b0);

    // random phase checked by the model every cycle
    cur_req = "R2/R4/R5/R6/R7";
    for (int i = 0; i < 400; i++) begin
      step();
      if (($urandom % 3) == 0) pins = 8'($urandom);
      if (($urandom % 8) == 0) ctrl = 8'($urandom);
      clr_rd = (($urandom % 6) == 0);
    end
    step();
    clr_rd = 1'b0;
    steps(4);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule